// File: doc/BRIEF.md
# Integer Execute Unit

A single-cycle execute stage for a small 32-bit integer instruction subset. Each cycle it takes one instruction word, splits it into its fields, reads two source operands from a 32-entry register file held inside the block, forms the result and, on the next rising clock edge, writes that result to the destination register. The supported operations are register add, subtract, signed set-less-than and logical left shift, and the immediate forms add, signed set-less-than, AND, OR and load-upper.

The result of the instruction presented this cycle is always visible on `res_data`, even when the strobe is low. The destination index and a write flag come out beside it. A caller can therefore read any register without changing state. It presents a register add of that register with register 0 and holds the strobe low.

Top module: `iex_unit`

## Requirements
- R1: After a synchronous active-low reset every register reads as zero.
- R2: Register 0 always reads as zero. An instruction whose destination index is 0 does not write, and `res_wr` stays low for it.
- R3: Opcode 0 with funct 32 computes rs + rt, and with funct 34 computes rs - rt, both modulo 2^32. rs is bits 25-21, rt is bits 20-16, and the destination is rd in bits 15-11.
- R4: Opcode 0 with funct 42 writes 1 when rs is less than rt as signed two's-complement values, and writes 0 otherwise.
- R5: Opcode 0 with funct 0 writes rt shifted left by shamt (bits 10-6), with zeros shifted in.
- R6: Opcode 8 writes rs plus the sign-extended 16-bit immediate (bits 15-0) to rt.
- R7: Opcode 10 writes 1 to rt when rs is less than the sign-extended immediate under a signed compare, and writes 0 otherwise.
- R8: Opcode 12 writes rs AND the zero-extended immediate to rt. Opcode 13 writes rs OR the zero-extended immediate to rt.
- R9: Opcode 15 writes the immediate into bits 31-16 of rt and clears bits 15-0.
- R10: A register changes only on a rising edge at which `issue_vld` is high and the instruction is recognised. An unrecognised opcode or funct writes nothing. `res_wr` is high exactly when a write will take place, and `res_dst` then names the register to be written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_vld | input | 1 | Instruction strobe; high commits the write-back |
| instr | input | 32 | Instruction word |
| res_data | output | 32 | Result of the current instruction |
| res_dst | output | 5 | Destination register index |
| res_wr | output | 1 | Write-back takes place at the next rising edge |

## Verification
The cases that are hardest to reach from the ports are the signed compares at the sign boundary and the mix of sign- and zero-extended immediates with bit 15 set. Both need specific register contents first, and the only way to load a register is through the instructions themselves. The stimulus therefore builds boundary constants such as 0x80000000, 0x7FFFFFFF and all-ones with load-upper followed by OR-immediate. It then compares these values against each other and against immediates 0x8000, 0x7FFF and 0xFFFF, and after that runs a long pseudo-random stream. Register contents are read back by issuing strobe-low adds against register 0, so writes aimed at register 0, unrecognised codes and idle cycles can all be shown to leave state untouched.

// File: rtl/iex_pkg.sv
// Shared encodings and types for the integer execute unit.
// Assumes the fixed 32-bit instruction layout: opcode[31:26], rs[25:21],
// rt[20:16], rd[15:11], shamt[10:6], funct[5:0], imm[15:0].
package iex_pkg;

    localparam int unsigned OPC_W   = 6;
    localparam int unsigned FN_W    = 6;
    localparam int unsigned RIDX_W  = 5;
    localparam int unsigned SHAMT_W = 5;
    localparam int unsigned IMM_W   = 16;

    localparam logic [OPC_W-1:0] OPC_REG  = 6'd0;
    localparam logic [OPC_W-1:0] OPC_ADDI = 6'd8;
    localparam logic [OPC_W-1:0] OPC_SLTI = 6'd10;
    localparam logic [OPC_W-1:0] OPC_ANDI = 6'd12;
    localparam logic [OPC_W-1:0] OPC_ORI  = 6'd13;
    localparam logic [OPC_W-1:0] OPC_LUI  = 6'd15;

    localparam logic [FN_W-1:0] FN_SLL = 6'd0;
    localparam logic [FN_W-1:0] FN_ADD = 6'd32;
    localparam logic [FN_W-1:0] FN_SUB = 6'd34;
    localparam logic [FN_W-1:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SLT,
        ALU_SLL,
        ALU_AND,
        ALU_OR,
        ALU_PASSB
    } alu_op_e;

    typedef enum logic [1:0] {
        IMM_SIGN,
        IMM_ZERO,
        IMM_UPPER
    } imm_kind_e;

    typedef struct packed {
        logic               legal;
        alu_op_e            alu_op;
        logic               use_imm;
        imm_kind_e          imm_kind;
        logic [RIDX_W-1:0]  rs;
        logic [RIDX_W-1:0]  rt;
        logic [RIDX_W-1:0]  dst;
        logic [SHAMT_W-1:0] shamt;
        logic [IMM_W-1:0]   imm;
    } dec_t;

endpackage

// File: rtl/iex_decode.sv
// Instruction decoder: splits the word into fields, picks the ALU operation,
// the destination (rd for register forms, rt for immediate forms) and the
// extended immediate. Assumes XLEN >= 16.
module iex_decode
    import iex_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [31:0]     instr,
    output dec_t            dec,
    output logic [XLEN-1:0] imm_ext
);

    localparam int unsigned PAD_W = XLEN - IMM_W;

    logic [OPC_W-1:0]  opc;
    logic [FN_W-1:0]   fn;
    logic [RIDX_W-1:0] rd;

    assign opc = instr[31:26];
    assign fn  = instr[5:0];
    assign rd  = instr[15:11];

    // Field extraction and operation select.
    always_comb begin
        dec          = '0;
        dec.rs       = instr[25:21];
        dec.rt       = instr[20:16];
        dec.shamt    = instr[10:6];
        dec.imm      = instr[15:0];
        dec.dst      = rd;
        dec.alu_op   = ALU_ADD;
        dec.imm_kind = IMM_SIGN;
        unique case (opc)
            OPC_REG: begin
                dec.legal = 1'b1;
                unique case (fn)
                    FN_ADD:  dec.alu_op = ALU_ADD;
                    FN_SUB:  dec.alu_op = ALU_SUB;
                    FN_SLT:  dec.alu_op = ALU_SLT;
                    FN_SLL:  dec.alu_op = ALU_SLL;
                    default: dec.legal  = 1'b0;
                endcase
            end
            OPC_ADDI: begin
                dec.legal = 1'b1; dec.use_imm = 1'b1; dec.dst = instr[20:16];
                dec.alu_op = ALU_ADD; dec.imm_kind = IMM_SIGN;
            end
            OPC_SLTI: begin
                dec.legal = 1'b1; dec.use_imm = 1'b1; dec.dst = instr[20:16];
                dec.alu_op = ALU_SLT; dec.imm_kind = IMM_SIGN;
            end
            OPC_ANDI: begin
                dec.legal = 1'b1; dec.use_imm = 1'b1; dec.dst = instr[20:16];
                dec.alu_op = ALU_AND; dec.imm_kind = IMM_ZERO;
            end
            OPC_ORI: begin
                dec.legal = 1'b1; dec.use_imm = 1'b1; dec.dst = instr[20:16];
                dec.alu_op = ALU_OR; dec.imm_kind = IMM_ZERO;
            end
            OPC_LUI: begin
                dec.legal = 1'b1; dec.use_imm = 1'b1; dec.dst = instr[20:16];
                dec.alu_op = ALU_PASSB; dec.imm_kind = IMM_UPPER;
            end
            default: dec.legal = 1'b0;
        endcase
    end

    // Immediate widening according to the selected treatment.
    always_comb begin
        unique case (dec.imm_kind)
            IMM_ZERO:  imm_ext = {{PAD_W{1'b0}}, dec.imm};
            IMM_UPPER: imm_ext = {dec.imm, {PAD_W{1'b0}}};
            default:   imm_ext = {{PAD_W{dec.imm[IMM_W-1]}}, dec.imm};
        endcase
    end

endmodule

// File: rtl/iex_regfile.sv
// Register file with two combinational read ports and one write port.
// Entry 0 has no storage and reads as zero. The other entries clear on a
// synchronous active-low reset.
module iex_regfile #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned NREG = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic [XLEN-1:0]         wr_data,
    input  logic [$clog2(NREG)-1:0] rd_idx_a,
    input  logic [$clog2(NREG)-1:0] rd_idx_b,
    output logic [XLEN-1:0]         rd_data_a,
    output logic [XLEN-1:0]         rd_data_b
);

    localparam int unsigned IDX_W = $clog2(NREG);

    logic [NREG*XLEN-1:0] flat;

    for (genvar i = 0; i < NREG; i++) begin : g_ent
        if (i == 0) begin : g_zero
            assign flat[XLEN-1:0] = '0;
        end else begin : g_flop
            logic [XLEN-1:0] q;
            // Capture the write-back aimed at this entry.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                    q <= wr_data;
                end
            end
            assign flat[i*XLEN +: XLEN] = q;
        end
    end

    assign rd_data_a = flat[rd_idx_a*XLEN +: XLEN];
    assign rd_data_b = flat[rd_idx_b*XLEN +: XLEN];

endmodule

// File: rtl/iex_alu.sv
// Integer ALU: add, subtract, signed less-than, left shift, AND, OR, and a
// pass of operand b for the upper-half load. Wraps modulo 2^XLEN.
module iex_alu
    import iex_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  alu_op_e             op,
    input  logic [XLEN-1:0]     a,
    input  logic [XLEN-1:0]     b,
    input  logic [SHAMT_W-1:0]  shamt,
    output logic [XLEN-1:0]     y
);

    logic lt_signed;

    assign lt_signed = $signed(a) < $signed(b);

    // Result select.
    always_comb begin
        unique case (op)
            ALU_SUB:   y = a - b;
            ALU_SLT:   y = {{(XLEN-1){1'b0}}, lt_signed};
            ALU_SLL:   y = b << shamt;
            ALU_AND:   y = a & b;
            ALU_OR:    y = a | b;
            ALU_PASSB: y = b;
            default:   y = a + b;
        endcase
    end

endmodule

// File: rtl/iex_unit.sv
// Single-cycle execute stage: decode, register read, ALU, write-back on the
// rising edge while issue_vld is high. Assumes one instruction per cycle and
// no hazards beyond the write-then-read order given by the clock.
module iex_unit
    import iex_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    parameter int unsigned NREG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_vld,
    input  logic [31:0]     instr,
    output logic [XLEN-1:0] res_data,
    output logic [4:0]      res_dst,
    output logic            res_wr
);

    dec_t            dec;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] src_a;
    logic [XLEN-1:0] src_b;
    logic [XLEN-1:0] opnd_b;

    iex_decode #(.XLEN(XLEN)) u_dec (
        .instr   (instr),
        .dec     (dec),
        .imm_ext (imm_ext)
    );

    iex_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (res_wr),
        .wr_idx    (dec.dst),
        .wr_data   (res_data),
        .rd_idx_a  (dec.rs),
        .rd_idx_b  (dec.rt),
        .rd_data_a (src_a),
        .rd_data_b (src_b)
    );

    assign opnd_b = dec.use_imm ? imm_ext : src_b;

    iex_alu #(.XLEN(XLEN)) u_alu (
        .op    (dec.alu_op),
        .a     (src_a),
        .b     (opnd_b),
        .shamt (dec.shamt),
        .y     (res_data)
    );

    assign res_dst = dec.dst;
    assign res_wr  = issue_vld && dec.legal && (dec.dst != '0);

endmodule

// File: rtl/iex_unit_chk.sv
// Property checker for iex_unit, attached with bind.
module iex_unit_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue_vld,
    input logic [31:0]     instr,
    input logic [XLEN-1:0] res_data,
    input logic [4:0]      res_dst,
    input logic            res_wr
);

    // R10
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_vld |-> !res_wr);

    // R2
    zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr |-> (res_dst != 5'd0));

    // R2
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:16] == 16'd0 && instr[5:0] == 6'd32) |-> (res_data == '0));

    // R4
    slt_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((instr[31:26] == 6'd0 && instr[5:0] == 6'd42) || instr[31:26] == 6'd10)
        |-> (res_data[XLEN-1:1] == '0));

    // R8
    andi_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] == 6'd12) |-> (res_data[XLEN-1:16] == '0));

    // R9
    lui_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] == 6'd15) |-> (res_data[15:0] == 16'd0));

    // R10
    dst_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr |-> (res_dst == ((instr[31:26] == 6'd0) ? instr[15:11] : instr[20:16])));

endmodule

bind iex_unit iex_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/iex_unit_bench.sv
module iex_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_vld = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] res_data;
    logic [4:0]  res_dst;
    logic        res_wr;

    int total = 0;
    int bad = 0;
    logic [31:0] refm [32];
    logic [31:0] seed = 32'h1234_5678;

    always #2 clk = ~clk;

    iex_unit u_iex_unit (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .instr(instr),
        .res_data(res_data), .res_dst(res_dst), .res_wr(res_wr)
    );

    function automatic logic [31:0] rfmt(input [4:0] rs, input [4:0] rt,
                                         input [4:0] rd, input [4:0] sh, input [5:0] fn);
        return {6'd0, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] ifmt(input [5:0] op, input [4:0] rs,
                                         input [4:0] rt, input [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic string tag_of(input [31:0] ins);
        case (ins[31:26])
            6'd0: case (ins[5:0])
                6'd32, 6'd34: return "R3";
                6'd42: return "R4";
                6'd0:  return "R5";
                default: return "R10";
            endcase
            6'd8:  return "R6";
            6'd10: return "R7";
            6'd12, 6'd13: return "R8";
            6'd15: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Reference model of one instruction against refm.
    task automatic model(input [31:0] ins, output bit ok, output [4:0] dst,
                         output [31:0] val);
        logic [31:0] a, b, se, ze;
        a  = refm[ins[25:21]];
        b  = refm[ins[20:16]];
        se = {{16{ins[15]}}, ins[15:0]};
        ze = {16'd0, ins[15:0]};
        ok = 1'b1; dst = ins[20:16]; val = '0;
        case (ins[31:26])
            6'd0: begin
                dst = ins[15:11];
                case (ins[5:0])
                    6'd32: val = a + b;
                    6'd34: val = a - b;
                    6'd42: val = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    6'd0:  val = b << ins[10:6];
                    default: ok = 1'b0;
                endcase
            end
            6'd8:  val = a + se;
            6'd10: val = ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
            6'd12: val = a & ze;
            6'd13: val = a | ze;
            6'd15: val = {ins[15:0], 16'd0};
            default: ok = 1'b0;
        endcase
    endtask

    task automatic chk(input string tag, input [31:0] act, input [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one instruction for a cycle and check its outputs.
    task automatic issue(input [31:0] ins, input bit v);
        bit ok; logic [4:0] dst; logic [31:0] val; bit ew;
        model(ins, ok, dst, val);
        @(negedge clk);
        instr = ins; issue_vld = v;
        #1;
        ew = v && ok && (dst != 5'd0);
        chk(tag_of(ins), {31'd0, res_wr}, {31'd0, ew});
        if (ok) chk(tag_of(ins), res_data, val);
        if (ew) chk("R10", {27'd0, res_dst}, {27'd0, dst});
        if (ew) refm[dst] = val;
        @(posedge clk);
    endtask

    // Read a register through a strobe-low add with register 0.
    task automatic peek(input [4:0] idx, input [31:0] exp, input string tag);
        @(negedge clk);
        instr = rfmt(idx, 5'd0, 5'd1, 5'd0, 6'd32); issue_vld = 1'b0;
        #1;
        chk(tag, res_data, exp);
        chk("R10", {31'd0, res_wr}, 32'd0);
    endtask

    task automatic load(input [4:0] r, input [31:0] v);
        issue(ifmt(6'd15, 5'd0, r, v[31:16]), 1'b1);
        issue(ifmt(6'd13, r, r, v[15:0]), 1'b1);
    endtask

    function automatic logic [31:0] lcg();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    initial begin
        #(4 * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] bnd [8];
        logic [15:0] ibnd [6];
        bnd[0] = 32'h8000_0000; bnd[1] = 32'h7FFF_FFFF; bnd[2] = 32'hFFFF_FFFF;
        bnd[3] = 32'h0000_0000; bnd[4] = 32'h0000_0001; bnd[5] = 32'hFFFF_8000;
        bnd[6] = 32'h0000_7FFF; bnd[7] = 32'h8000_0001;
        ibnd[0] = 16'h8000; ibnd[1] = 16'h7FFF; ibnd[2] = 16'hFFFF;
        ibnd[3] = 16'h0000; ibnd[4] = 16'h0001; ibnd[5] = 16'hA5A5;
        for (int i = 0; i < 32; i++) refm[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: every register cleared by reset
        for (int i = 0; i < 32; i++) peek(5'(i), 32'd0, "R1");

        // Boundary constants in r1..r8 via upper load then OR
        for (int i = 0; i < 8; i++) load(5'(i + 1), bnd[i]);
        for (int i = 0; i < 8; i++) peek(5'(i + 1), bnd[i], "R9");

        // R4, R3: register compare/add/sub over all boundary pairs
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
                issue(rfmt(5'(i + 1), 5'(j + 1), 5'd20, 5'd0, 6'd42), 1'b1);
                issue(rfmt(5'(i + 1), 5'(j + 1), 5'd21, 5'd0, 6'd32), 1'b1);
                issue(rfmt(5'(i + 1), 5'(j + 1), 5'd22, 5'd0, 6'd34), 1'b1);
            end

        // R6, R7, R8: immediates with and without bit 15
        for (int i = 0; i < 8; i++)
            for (int k = 0; k < 6; k++) begin
                issue(ifmt(6'd8,  5'(i + 1), 5'd23, ibnd[k]), 1'b1);
                issue(ifmt(6'd10, 5'(i + 1), 5'd24, ibnd[k]), 1'b1);
                issue(ifmt(6'd12, 5'(i + 1), 5'd25, ibnd[k]), 1'b1);
                issue(ifmt(6'd13, 5'(i + 1), 5'd26, ibnd[k]), 1'b1);
            end

        // R5: every shift amount
        for (int s = 0; s < 32; s++) begin
            issue(rfmt(5'd0, 5'd8, 5'd27, 5'(s), 6'd0), 1'b1);
            peek(5'd27, bnd[7] << s, "R5");
        end

        // R2: writes aimed at register 0 are dropped
        issue(ifmt(6'd8, 5'd2, 5'd0, 16'h0005), 1'b1);
        issue(rfmt(5'd2, 5'd3, 5'd0, 5'd0, 6'd32), 1'b1);
        issue(ifmt(6'd15, 5'd0, 5'd0, 16'hBEEF), 1'b1);
        peek(5'd0, 32'd0, "R2");

        // R10: strobe low and unrecognised codes leave state unchanged
        issue(ifmt(6'd8, 5'd2, 5'd9, 16'h0001), 1'b0);
        peek(5'd9, refm[9], "R10");
        issue(ifmt(6'd35, 5'd2, 5'd9, 16'h0001), 1'b1);
        peek(5'd9, refm[9], "R10");
        issue(rfmt(5'd2, 5'd3, 5'd9, 5'd0, 6'd33), 1'b1);
        peek(5'd9, refm[9], "R10");

        // Pseudo-random mix
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r, w;
            logic [15:0] imm;
            r = lcg();
            imm = (r[3:0] < 6) ? ibnd[r[3:0]] : lcg() >> 16;
            case (r[7:4] % 10)
                0: w = rfmt(r[12:8], r[17:13], r[22:18], 5'd0, 6'd32);
                1: w = rfmt(r[12:8], r[17:13], r[22:18], 5'd0, 6'd34);
                2: w = rfmt(r[12:8], r[17:13], r[22:18], 5'd0, 6'd42);
                3: w = rfmt(r[12:8], r[17:13], r[22:18], r[27:23], 6'd0);
                4: w = ifmt(6'd8,  r[12:8], r[17:13], imm);
                5: w = ifmt(6'd10, r[12:8], r[17:13], imm);
                6: w = ifmt(6'd12, r[12:8], r[17:13], imm);
                7: w = ifmt(6'd13, r[12:8], r[17:13], imm);
                8: w = ifmt(6'd15, r[12:8], r[17:13], imm);
                default: w = ifmt(r[31:26], r[12:8], r[17:13], imm);
            endcase
            issue(w, r[30:28] != 3'd0);
        end

        // Final register dump against the model
        for (int i = 0; i < 32; i++) peek(5'(i), refm[i], "R10");

        @(negedge clk) issue_vld = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule